// File: doc/BRIEF.md
# Converter Serial Result Port (Chip-Select Mode, No Busy Flag)

This block is the digital side of an 18-bit sampling converter's three-wire serial port. A rising convert strobe starts a conversion of fixed length, timed in system-clock cycles. When the conversion ends, the block latches the parallel sample word and holds it. A later falling convert strobe opens the data output and drives the most significant bit. Each following falling serial-clock edge moves the next bit out.

The output returns to the released state after the last bit, or at once when the strobe rises again, whichever comes first. The released (high-impedance) state is shown by a separate output-enable that is low. The serial clock and the strobe are asynchronous to the system clock. Each passes through a synchronizer and an edge detector, so the system clock must run at least four times as fast as the serial clock.

Top module: `serial_conv_port`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `busy_o` is 0 and `sdo_o` is 0. `sdo_o` reads 0 whenever `sdo_oe_o` is 0.
- R2: A rising edge on `cnv_i` while `cfg_i` is 1 and no conversion is running sets `busy_o` to 1 and forces `sdo_oe_o` to 0.
- R3: `busy_o` stays 1 for exactly `CONV_CYCLES` system-clock cycles per conversion.
- R4: Toggling `cnv_i` during a conversion neither shortens nor restarts it, and a low strobe during a conversion never sets `sdo_oe_o`.
- R5: A falling edge on `cnv_i` after a completed conversion sets `sdo_oe_o` to 1 and drives bit 17 (the MSB) of the latched word on `sdo_o`.
- R6: Each later falling edge of `sck_i` moves `sdo_o` to the next lower bit. A rising edge of `sck_i` leaves `sdo_o` unchanged.
- R7: On the 18th falling edge of `sck_i` after the read began, `sdo_oe_o` returns to 0.
- R8: A rising edge on `cnv_i` during a read sets `sdo_oe_o` to 0 at once and starts a new conversion.
- R9: A rising edge on `cnv_i` while `cfg_i` is 0 starts no conversion.
- R10: The word is latched from `sample_i` on the last conversion cycle and is unaffected by later changes of `sample_i`. It can be read once only: a further strobe fall with no new conversion leaves `sdo_oe_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_i | input | 1 | Convert strobe; rise starts a conversion, fall starts a read |
| sck_i | input | 1 | Serial clock from the host |
| cfg_i | input | 1 | Configuration input, 1 selects chip-select mode |
| sample_i | input | 18 | Parallel sample word to be converted |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_oe_o | output | 1 | Data output enable; 0 stands for high impedance |
| busy_o | output | 1 | Conversion in progress |

## Verification
Two events can land in the same cycle. The first is a strobe rise that ends a read in progress. The second is the start of the next conversion triggered by that same edge. The bench raises `cnv_i` in the middle of a read, after a new sample word has been presented. It then checks that the output enable drops at the same time as `busy_o` rises, and that the busy window still spans the full count. Finally, the next full read must return the new word and not the rest of the old one.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
   // one-cycle edge pulses produced in the system-clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync
   import serial_port_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  din,
   output edge_t ev
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign ev.rise = chain[STAGES-1] & ~prev;
   assign ev.fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
   parameter int CONV_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

   logic [CW-1:0] cnt;

   generate
      if (CONV_CYCLES < 1) begin : g_bad
         $error("conv_timer: CONV_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (start && !busy) begin
         cnt  <= LOAD;
         busy <= 1'b1;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0);

   // R3
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

// File: rtl/shift_out.sv
module shift_out #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             load,
   input  logic [WIDTH-1:0] word,
   input  logic             shift,
   output logic             sdo,
   output logic             oe
);
   localparam int NW = $clog2(WIDTH);
   localparam logic [NW-1:0] LAST = NW'(WIDTH - 1);

   logic [WIDTH-1:0] sreg;
   logic [NW-1:0]    nbit;

   generate
      if (WIDTH < 2) begin : g_bad
         $error("shift_out: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         nbit <= '0;
         oe   <= 1'b0;
      end else if (stop) begin
         oe <= 1'b0;
      end else if (load) begin
         sreg <= word;
         nbit <= '0;
         oe   <= 1'b1;
      end else if (shift && oe) begin
         sreg <= {sreg[WIDTH-2:0], 1'b0};
         if (nbit == LAST) oe <= 1'b0;
         else              nbit <= nbit + 1'b1;
      end
   end

   assign sdo = oe & sreg[WIDTH-1];

   // R6
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(oe) && oe && !$past(shift) && !$past(load)) |-> $stable(sdo));
endmodule

// File: rtl/serial_conv_port.sv
module serial_conv_port
   import serial_port_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int CONV_CYCLES = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_i,
   input  logic              sck_i,
   input  logic              cfg_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              busy_o
);
   localparam int CKW = $clog2(CONV_CYCLES + 2);

   edge_t             cnv_ev, sck_ev;
   logic              start, done, load, ready;
   logic [DATA_W-1:0] result;

   generate
      if (DATA_W < 2)      begin : g_bad_w $error("DATA_W too small");      end
      if (CONV_CYCLES < 1) begin : g_bad_c $error("CONV_CYCLES too small"); end
   endgenerate

   edge_sync #(.STAGES(SYNC_STAGES)) u_cnv (
      .clk(clk), .rst_n(rst_n), .din(cnv_i), .ev(cnv_ev));
   edge_sync #(.STAGES(SYNC_STAGES)) u_sck (
      .clk(clk), .rst_n(rst_n), .din(sck_i), .ev(sck_ev));

   assign start = cnv_ev.rise & cfg_i;

   conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_o), .done(done));

   assign load = cnv_ev.fall & ready & ~busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         ready  <= 1'b0;
      end else if (done) begin
         result <= sample_i;
         ready  <= 1'b1;
      end else if (load) begin
         ready  <= 1'b0;
      end
   end

   shift_out #(.WIDTH(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .stop(cnv_ev.rise), .load(load),
      .word(result), .shift(sck_ev.fall), .sdo(sdo_o), .oe(sdo_oe_o));

   // checker-side run length of busy
   logic [CKW-1:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_run <= '0;
      else if (busy_o) busy_run <= busy_run + 1'b1;
      else             busy_run <= '0;
   end

   // R3
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_run == CKW'(CONV_CYCLES)));
   // R4
   oe_idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sdo_oe_o);
   // R5
   oe_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe_o) |-> $past(cnv_ev.fall));
   // R8
   rise_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnv_ev.rise) |-> !sdo_oe_o);
   // R6
   sck_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sck_ev.rise) && $past(sdo_oe_o) && sdo_oe_o) |-> $stable(sdo_o));
endmodule

// File: tb/sim_serial_conv_port.sv
module sim_serial_conv_port;
   localparam int W    = 18;
   localparam int CONV = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnv = 1'b0, sck = 1'b0, cfg = 1'b1;
   logic [W-1:0] sample = '0;
   logic         sdo, oe, busy;
   int           total = 0, bad = 0;

   always #2 clk = ~clk;

   serial_conv_port #(.DATA_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .cfg_i(cfg),
      .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R1 oe", oe, 0);
      chk("R1 busy", busy, 0);
      chk("R1 sdo", sdo, 0);
   endtask

   // start a conversion; optionally toggle the strobe inside it
   task automatic t_convert(input logic [W-1:0] word, input bit toggle);
      int n = 0;
      int oe_seen = 0;
      sample = word;
      cnv = 1'b1;
      tick(5);
      chk("R2 busy", busy, 1);
      chk("R2 oe", oe, 0);
      n = busy ? 3 : 0;
      for (int i = 0; i < CONV + 8; i++) begin
         if (toggle && i == 3) cnv = 1'b0;
         if (toggle && i == 9) cnv = 1'b1;
         tick(1);
         if (busy) n++;
         if (oe) oe_seen = 1;
      end
      chk(toggle ? "R4 length" : "R3 length", n, CONV);
      chk("R4 oe during conversion", oe_seen, 0);
      sample = ~word;   // R10: later changes must not matter
   endtask

   // read nbits bits, then end either by count or by strobe rise
   task automatic t_read(input logic [W-1:0] word, input int nbits,
                         input logic [W-1:0] next_word);
      cnv = 1'b0;
      tick(5);
      chk("R5 oe", oe, 1);
      chk("R5 msb", sdo, word[W-1]);
      for (int i = 1; i <= nbits; i++) begin
         sck = 1'b1;
         tick(4);
         chk("R6 rise hold", sdo, word[W-i]);
         sck = 1'b0;
         tick(4);
         if (i < W) chk("R6 bit", sdo, word[W-1-i]);
         else begin
            chk("R7 oe", oe, 0);
            chk("R1 sdo idle", sdo, 0);
         end
      end
      if (nbits < W) begin
         sample = next_word;
         cnv = 1'b1;
         tick(5);
         chk("R8 oe", oe, 0);
         chk("R8 busy", busy, 1);
         tick(CONV + 4);
         chk("R8 done", busy, 0);
      end
   endtask

   task automatic t_cfg_low_and_reread();
      cfg = 1'b0;
      cnv = 1'b1;
      tick(6);
      chk("R9 busy", busy, 0);
      cnv = 1'b0;
      tick(6);
      chk("R10 no reread", oe, 0);
      cfg = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_convert(18'h2A5C3, 1'b0);
      t_read(18'h2A5C3, W, '0);
      t_cfg_low_and_reread();
      t_convert(18'h3FFFF, 1'b1);
      t_read(18'h3FFFF, 5, 18'h12345);
      t_read(18'h12345, W, '0);
      t_convert(18'h20001, 1'b0);
      t_read(18'h20001, W, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule